// File: doc/BRIEF.md
# Printer Port Register Block

This block is the host-facing register set of a byte-wide compatibility-mode printer port. A host bus selects one of eight byte registers through a 3-bit offset. Three of them are live: a data register, a status register and a control register. Offsets 3 to 7 read as 0xFF and ignore writes.

No printer is attached. The block plays the printer's side of the handshake itself. A rising strobe bit written through the control register clears the busy flag and releases the current write-data byte on a valid/ready byte output. Later status reads walk the acknowledge and busy flags through their sequence until the port is ready again.

The control register also arms a level interrupt. The interrupt is set by a strobe-low control write and cleared by a status read. A side input loads the read-data register, and the data register returns that value when the direction bit is set.

Top module: `pp_regs`

## Requirements
- R1: After reset, a data read returns 0xFF, a status read returns 0xD8, a control read returns 0x0C, `irqOut` is 0 and `outValid` is 0.
- R2: The register offset is `busAddr[2:0]`, with data at 0, status at 1 and control at 2. A read at any other offset returns 0xFF, and a write there changes no register.
- R3: A data read returns the read-data register when control bit 5 (direction) is 1, and returns the last byte written to offset 0 when that bit is 0.
- R4: A control write with bit 2 (init) at 0 sets the status register to 0xD8.
- R5: Some control writes have init (bit 2), select (bit 3) and strobe (bit 0) all at 1. Such a write clears status bit 7 (busy, active low). It also emits the write-data byte, but only when the stored strobe bit was 0 before the write.
- R6: An emitted byte holds `outValid` high with `outData` stable until `outReady` is seen high. Any strobe edge that arrives while a byte is held emits nothing.
- R7: Some control writes have init and select at 1 and strobe at 0. Such a write sets the interrupt pending flag when the stored control had bit 4 (interrupt enable) at 1. `irqOut` shows the pending flag.
- R8: A status read returns the current status and clears the pending flag. If status bit 7 is 0 and the stored strobe is 0, the read then clears bit 6 (ack) when ack is set. When ack is clear, the read sets both ack and bit 7.
- R9: A control read returns the byte last written to offset 2.
- R10: A cycle with `extLoad` high copies `extData` into the read-data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register offset; the low 3 bits decode |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe; a status read has side effects |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the offset presented |
| extData | input | 8 | Value for the read-data register |
| extLoad | input | 1 | Loads extData into the read-data register |
| outValid | output | 1 | Emitted byte is waiting |
| outData | output | 8 | Emitted byte |
| outReady | input | 1 | Sink accepts the byte |
| irqOut | output | 1 | Level interrupt |

## Verification
The handshake is tried with three input patterns.

- A clean low-to-high strobe with a ready sink shows a byte is released and busy drops. The status reads that follow then step through the ack-clear and ack-and-busy-set phases and stop once busy is high.
- A repeated high strobe shows that a level is not taken for an edge. The scoreboard queue shows that no second byte appears.
- A strobe edge while the sink stalls shows the held byte wins over the new one.

Interrupt enable is tested by writing it in the same control write that drops strobe. The pending flag should be set only on the following write, because it follows the stored enable and not the incoming one.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int DATA_W = 8;
  localparam int OFF_W  = 3;

  localparam logic [OFF_W-1:0] OFF_DATA = 3'd0;
  localparam logic [OFF_W-1:0] OFF_STAT = 3'd1;
  localparam logic [OFF_W-1:0] OFF_CTRL = 3'd2;

  // status bit positions
  localparam int ST_NBUSY = 7;
  localparam int ST_ACK   = 6;
  // control bit positions
  localparam int CT_DIR  = 5;
  localparam int CT_IEN  = 4;
  localparam int CT_SEL  = 3;
  localparam int CT_INIT = 2;
  localparam int CT_STB  = 0;

  localparam logic [DATA_W-1:0] STAT_IDLE = 8'hD8;
  localparam logic [DATA_W-1:0] CTRL_RST  = 8'h0C;
  localparam logic [DATA_W-1:0] FILL      = 8'hFF;

  typedef struct packed {
    logic wrData;
    logic wrCtrl;
    logic rdStatus;
    logic loadIn;
  } strobe_t;
endpackage

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              extLoad,
  output logic [OFF_W-1:0]  regSel,
  output strobe_t           stb
);
  logic rdOnly;

  assign regSel = busAddr[OFF_W-1:0];
  // a write takes the cycle; a read presented with it has no side effect
  assign rdOnly = busRd && !busWr;

  always_comb begin
    stb          = '0;
    stb.wrData   = busWr && (regSel == OFF_DATA);
    stb.wrCtrl   = busWr && (regSel == OFF_CTRL);
    stb.rdStatus = rdOnly && (regSel == OFF_STAT);
    stb.loadIn   = extLoad;
  end

  a_r2_one_reg_op: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrData, stb.wrCtrl, stb.rdStatus}));
endmodule

// File: rtl/pp_dpath.sv
module pp_dpath
  import pp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [OFF_W-1:0]  regSel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] extData,
  output logic [DATA_W-1:0] rdata,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outReady,
  output logic              irqOut
);
  logic [DATA_W-1:0] dataW, dataR, status, control;
  logic              pending;
  logic              strobeWr, strobeLowWr;

  assign strobeWr    = stb.wrCtrl && wdata[CT_INIT] && wdata[CT_SEL] && wdata[CT_STB];
  assign strobeLowWr = stb.wrCtrl && wdata[CT_INIT] && wdata[CT_SEL] && !wdata[CT_STB];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataW    <= FILL;
      dataR    <= FILL;
      status   <= STAT_IDLE;
      control  <= CTRL_RST;
      pending  <= 1'b0;
      outValid <= 1'b0;
      outData  <= FILL;
    end else begin
      if (stb.loadIn) dataR <= extData;
      if (stb.wrData) dataW <= wdata;
      if (outValid && outReady) outValid <= 1'b0;
      if (stb.wrCtrl) begin
        if (!wdata[CT_INIT]) status <= STAT_IDLE;
        control <= wdata;
      end
      if (strobeWr) begin
        status[ST_NBUSY] <= 1'b0;
        if (!control[CT_STB] && !outValid) begin
          outValid <= 1'b1;
          outData  <= dataW;
        end
      end
      if (strobeLowWr && control[CT_IEN]) pending <= 1'b1;
      if (stb.rdStatus) begin
        pending <= 1'b0;
        if (!status[ST_NBUSY] && !control[CT_STB]) begin
          if (status[ST_ACK]) status[ST_ACK] <= 1'b0;
          else begin
            status[ST_ACK]   <= 1'b1;
            status[ST_NBUSY] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    case (regSel)
      OFF_DATA: rdata = control[CT_DIR] ? dataR : dataW;
      OFF_STAT: rdata = status;
      OFF_CTRL: rdata = control;
      default:  rdata = FILL;
    endcase
  end

  assign irqOut = pending;

  a_r4_init_idle: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrCtrl && !wdata[CT_INIT]) |=> (status == STAT_IDLE));
  a_r5_busy_drop: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrCtrl && wdata[CT_INIT] && wdata[CT_SEL] && wdata[CT_STB]) |=> !status[ST_NBUSY]);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(stb.wrCtrl));
  a_r8_irq_clear: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdStatus |=> !irqOut);
endmodule

// File: rtl/pp_regs.sv
module pp_regs
  import pp_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic [7:0]        extData,
  input  logic              extLoad,
  output logic              outValid,
  output logic [7:0]        outData,
  input  logic              outReady,
  output logic              irqOut
);
  strobe_t          stb;
  logic [OFF_W-1:0] regSel;

  pp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .extLoad(extLoad), .regSel(regSel), .stb(stb)
  );

  pp_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .regSel(regSel), .wdata(busWdata),
    .extData(extData), .rdata(busRdata), .outValid(outValid), .outData(outData),
    .outReady(outReady), .irqOut(irqOut)
  );
endmodule

// File: tb/sim_pp_regs.sv
module sim_pp_regs;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWr = 1'b0, busRd = 1'b0, extLoad = 1'b0, outReady = 1'b0;
  logic [7:0] busWdata = '0, extData = '0, busRdata, outData;
  logic       outValid, irqOut;
  int         checks = 0, errors = 0;
  logic [7:0] expQ[$];
  bit         done = 0;

  always #2.5 clk = ~clk;

  pp_regs u0 (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .extData(extData), .extLoad(extLoad),
    .outValid(outValid), .outData(outData), .outReady(outReady), .irqOut(irqOut));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    #1 check(req, busRdata, exp);
    @(negedge clk); busRd = 1'b0;
  endtask

  // driver: write a byte and strobe it, pushing what the sink must see
  task automatic sendByte(input logic [7:0] d);
    wr(3'd0, d);
    expQ.push_back(d);
    wr(3'd2, 8'h0C);
    wr(3'd2, 8'h0D);
  endtask

  // monitor: scoreboard compare at each accepted transfer
  initial begin
    while (!done) begin
      @(negedge clk); #1;
      if (outValid && outReady) begin
        if (expQ.size() == 0) check("R5 unexpected byte", outData, 8'hxx);
        else check("R5/R6 emitted byte", outData, expQ.pop_front());
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(3'd0, 8'hFF, "R1 data");
    rd(3'd1, 8'hD8, "R1 status");
    rd(3'd2, 8'h0C, "R1 control");
    check("R1 irq", {7'd0, irqOut}, 8'h00);
    check("R1 outValid", {7'd0, outValid}, 8'h00);
    // R2 unused offsets
    rd(3'd5, 8'hFF, "R2 offset 5");
    wr(3'd3, 8'h00);
    wr(3'd7, 8'h00);
    rd(3'd2, 8'h0C, "R2 write at 3/7 left control");
    rd(3'd0, 8'hFF, "R2 write at 3/7 left data");
    // R10, R3, R9
    @(negedge clk); extData = 8'h5A; extLoad = 1'b1;
    @(negedge clk); extLoad = 1'b0;
    wr(3'd0, 8'h11);
    rd(3'd0, 8'h11, "R3 dir=0 gives write data");
    wr(3'd2, 8'h2C);
    rd(3'd0, 8'h5A, "R10/R3 dir=1 gives loaded data");
    rd(3'd2, 8'h2C, "R9 control readback");
    wr(3'd2, 8'h0C);
    // R5 strobe edge, R8 handshake sequence
    outReady = 1'b1;
    sendByte(8'hA5);
    rd(3'd1, 8'h58, "R5 busy cleared");
    rd(3'd1, 8'h58, "R8 no advance while strobe high");
    wr(3'd2, 8'h0C);
    rd(3'd1, 8'h58, "R8 first read");
    rd(3'd1, 8'h18, "R8 ack cleared");
    rd(3'd1, 8'hD8, "R8 ack and busy set");
    rd(3'd1, 8'hD8, "R8 idle stays");
    // R5 strobe level held: no second byte
    sendByte(8'h77);
    wr(3'd2, 8'h0D);
    // R4 init low restores idle status
    wr(3'd2, 8'h08);
    rd(3'd1, 8'hD8, "R4 init forces idle");
    wr(3'd2, 8'h0C);
    // R6 stalled sink
    outReady = 1'b0;
    sendByte(8'hC3);
    repeat (3) @(negedge clk);
    #1 check("R6 valid held", {7'd0, outValid}, 8'h01);
    wr(3'd2, 8'h0C);
    wr(3'd0, 8'h99);
    wr(3'd2, 8'h0D);
    #1 check("R6 data kept", outData, 8'hC3);
    @(negedge clk); outReady = 1'b1;
    repeat (3) @(negedge clk);
    #1 check("R6 released", {7'd0, outValid}, 8'h00);
    // R7 interrupt from stored enable
    wr(3'd2, 8'h1C);
    #1 check("R7 enable not yet stored", {7'd0, irqOut}, 8'h00);
    wr(3'd2, 8'h1C);
    #1 check("R7 irq set", {7'd0, irqOut}, 8'h01);
    rd(3'd1, 8'h58, "R8 status with irq");
    #1 check("R8 irq cleared", {7'd0, irqOut}, 8'h00);
    repeat (4) @(negedge clk);
    check("R5 scoreboard drained", 8'(expQ.size()), 8'h00);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule